// File: doc/BRIEF.md
# Segmented Multi-Bus Crosspoint Controller

This controller owns the switch settings of a row of processing elements (PEs) that share several parallel horizontal bus tracks. On every track, each PE column has its own bus segment. A crosspoint between two neighbouring columns joins their segments on one track when it closes. A PE that wants to talk to another PE raises a request that names the target. The controller then looks for a track on which every segment from the sender's column to the target's column is free. It reserves that span, closes the crosspoints inside it and reports the track it chose. The circuit stays the sender's until the sender raises its release line.

Each PE has a level request line and a target index. When several PEs request in the same cycle, the lowest-numbered one is served and the others receive no response. They hold their request and are served in a later cycle. Every served request gets exactly one response one clock later, either a grant with its track number or a busy refusal. A refusal leaves all state as it was. The reservation map and the crosspoint controls are outputs. Crosspoints are grouped by column: the group for gap j holds one control bit per track.

Top module: `segbus_xbar_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, there is no response, every segment is free (`seg_busy` all zero) and every crosspoint is open (`xp_close` all zero).
- R2: A valid request from sender s to target d gives a response in the next cycle with `resp_vld`=1, `resp_ok`=1, `resp_src`=s and `resp_trk` equal to the lowest track index on which every segment in columns min(s,d) through max(s,d) was free.
- R3: In the same cycle as a grant, `seg_busy[t*N_PE+c]` is 1 for every column c of the span on granted track t. `xp_close[j*N_TRK+t]` is 1 for every gap j with min(s,d) <= j < max(s,d). A closed crosspoint always has both neighbouring segments reserved on its track.
- R4: If no track has the whole span free, the response is `resp_ok`=0 with `resp_trk`=0, and no segment or crosspoint changes.
- R5: The request is refused as busy, with no state change, if the target equals the sender, if the target index is N_PE or larger, or if the sender already owns a circuit.
- R6: When several request lines are high in one cycle, only the lowest-indexed sender gets a response. If no request line is high, no response is given.
- R7: A release from a sender that owns a circuit frees exactly that circuit's segments and opens exactly its crosspoints in the next cycle. Other circuits keep their reservations.
- R8: A release from a sender that owns no circuit changes nothing.
- R9: A target below the sender is handled like one above: the span runs from the target column to the sender column.
- R10: When a release and a request arrive in the same cycle, the request is checked against the reservations held before that release. The release still takes effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | N_PE | Connection request line, one per sender PE |
| req_dst | input | N_PE*IW | Target index per sender; sender i uses bits [i*IW +: IW] |
| rel | input | N_PE | Release line, one per sender PE |
| resp_vld | output | 1 | A request was served in the previous cycle |
| resp_ok | output | 1 | 1 means granted, 0 means refused as busy |
| resp_src | output | IW | Index of the sender that was served |
| resp_trk | output | TW | Granted track; 0 on a refusal |
| seg_busy | output | N_TRK*N_PE | Segment reservation map; bit t*N_PE+c is column c on track t |
| xp_close | output | (N_PE-1)*N_TRK | Crosspoint controls grouped by gap; bit j*N_TRK+t joins columns j and j+1 on track t |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. In that cycle the response fields appear, and the reservation map and crosspoint controls already show the grant or release. The bench changes its inputs at a falling edge and lets one rising edge pass. It compares all outputs at the next falling edge with a reference model that it advances once per step. Each step therefore sees only the effect of its own stimulus, and each check is tagged with the requirement that the step exercises.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
    typedef enum logic [1:0] {
        SERVE_NONE  = 2'd0,
        SERVE_GRANT = 2'd1,
        SERVE_BUSY  = 2'd2
    } serve_kind_e;
endpackage

// File: rtl/segbus_span.sv
module segbus_span #(
    parameter int N_PE = 6,
    parameter int IW   = 3
) (
    input  logic [IW-1:0]   src,
    input  logic [IW-1:0]   dst,
    output logic [IW-1:0]   lo,
    output logic [IW-1:0]   hi,
    output logic [N_PE-1:0] mask,
    output logic            legal
);
    // endpoints in column order, independent of direction
    assign lo    = (src < dst) ? src : dst;
    assign hi    = (src < dst) ? dst : src;
    assign legal = ({1'b0, dst} < (IW+1)'(N_PE)) && (dst != src);

    for (genvar c = 0; c < N_PE; c++) begin : g_col
        assign mask[c] = (IW'(c) >= lo) && (IW'(c) <= hi);
    end
endmodule

// File: rtl/segbus_prio.sv
module segbus_prio #(
    parameter int N_PE = 6,
    parameter int IW   = 3
) (
    input  logic [N_PE-1:0] req,
    output logic            any,
    output logic [IW-1:0]   idx
);
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = N_PE - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/segbus_trk_pick.sv
module segbus_trk_pick #(
    parameter int N_PE  = 6,
    parameter int N_TRK = 4,
    parameter int TW    = 2
) (
    input  logic [N_TRK*N_PE-1:0] occ,
    input  logic [N_PE-1:0]       mask,
    output logic                  found,
    output logic [TW-1:0]         trk
);
    logic [N_TRK-1:0] free;

    for (genvar t = 0; t < N_TRK; t++) begin : g_trk
        assign free[t] = ~|(occ[t*N_PE +: N_PE] & mask);
    end

    assign found = |free;

    always_comb begin
        trk = '0;
        for (int t = N_TRK - 1; t >= 0; t--) begin
            if (free[t]) trk = TW'(t);
        end
    end
endmodule

// File: rtl/segbus_xp_map.sv
module segbus_xp_map #(
    parameter int N_PE  = 6,
    parameter int N_TRK = 4,
    parameter int IW    = 3,
    parameter int TW    = 2
) (
    input  logic [N_PE-1:0]          own_vld,
    input  logic [N_PE*TW-1:0]       own_trk,
    input  logic [N_PE*IW-1:0]       own_lo,
    input  logic [N_PE*IW-1:0]       own_hi,
    output logic [(N_PE-1)*N_TRK-1:0] xp_close
);
    for (genvar j = 0; j < N_PE - 1; j++) begin : g_gap
        for (genvar t = 0; t < N_TRK; t++) begin : g_trk
            always_comb begin
                xp_close[j*N_TRK + t] = 1'b0;
                for (int i = 0; i < N_PE; i++) begin
                    if (own_vld[i]
                        && (own_trk[i*TW +: TW] == TW'(t))
                        && (own_lo[i*IW +: IW] <= IW'(j))
                        && (own_hi[i*IW +: IW] >  IW'(j))) begin
                        xp_close[j*N_TRK + t] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/segbus_xbar_ctrl.sv
module segbus_xbar_ctrl
    import segbus_pkg::*;
#(
    parameter int N_PE  = 6,
    parameter int N_TRK = 4,
    localparam int IW   = (N_PE  > 1) ? $clog2(N_PE)  : 1,
    localparam int TW   = (N_TRK > 1) ? $clog2(N_TRK) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PE-1:0]           req_vld,
    input  logic [N_PE*IW-1:0]        req_dst,
    input  logic [N_PE-1:0]           rel,
    output logic                      resp_vld,
    output logic                      resp_ok,
    output logic [IW-1:0]             resp_src,
    output logic [TW-1:0]             resp_trk,
    output logic [N_TRK*N_PE-1:0]     seg_busy,
    output logic [(N_PE-1)*N_TRK-1:0] xp_close
);
    typedef struct packed {
        logic [N_PE-1:0]                own_vld;
        logic [N_PE-1:0][TW-1:0]        own_trk;
        logic [N_PE-1:0][IW-1:0]        own_lo;
        logic [N_PE-1:0][IW-1:0]        own_hi;
        logic [N_TRK-1:0][N_PE-1:0]     occ;
        logic                           resp_vld;
        logic                           resp_ok;
        logic [IW-1:0]                  resp_src;
        logic [TW-1:0]                  resp_trk;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic            win_any;
    logic [IW-1:0]   win_idx;
    logic [IW-1:0]   win_dst;
    logic [IW-1:0]   sp_lo, sp_hi;
    logic [N_PE-1:0] sp_mask;
    logic            sp_legal;
    logic            trk_found;
    logic [TW-1:0]   trk_sel;
    serve_kind_e     serve;

    segbus_prio #(.N_PE(N_PE), .IW(IW)) u_prio (
        .req (req_vld),
        .any (win_any),
        .idx (win_idx)
    );

    assign win_dst = req_dst[win_idx*IW +: IW];

    segbus_span #(.N_PE(N_PE), .IW(IW)) u_span (
        .src   (win_idx),
        .dst   (win_dst),
        .lo    (sp_lo),
        .hi    (sp_hi),
        .mask  (sp_mask),
        .legal (sp_legal)
    );

    segbus_trk_pick #(.N_PE(N_PE), .N_TRK(N_TRK), .TW(TW)) u_pick (
        .occ   (st_q.occ),
        .mask  (sp_mask),
        .found (trk_found),
        .trk   (trk_sel)
    );

    always_comb begin
        if (!win_any)
            serve = SERVE_NONE;
        else if (sp_legal && !st_q.own_vld[win_idx] && trk_found)
            serve = SERVE_GRANT;
        else
            serve = SERVE_BUSY;
    end

    always_comb begin
        st_d = st_q;

        // releases act on the pre-cycle ownership records
        for (int i = 0; i < N_PE; i++) begin
            if (rel[i] && st_q.own_vld[i]) begin
                st_d.own_vld[i] = 1'b0;
                for (int c = 0; c < N_PE; c++) begin
                    if ((IW'(c) >= st_q.own_lo[i]) && (IW'(c) <= st_q.own_hi[i]))
                        st_d.occ[st_q.own_trk[i]][c] = 1'b0;
                end
            end
        end

        st_d.resp_vld = (serve != SERVE_NONE);
        st_d.resp_ok  = (serve == SERVE_GRANT);
        st_d.resp_src = win_idx;
        st_d.resp_trk = '0;

        if (serve == SERVE_GRANT) begin
            st_d.resp_trk             = trk_sel;
            st_d.own_vld[win_idx]     = 1'b1;
            st_d.own_trk[win_idx]     = trk_sel;
            st_d.own_lo[win_idx]      = sp_lo;
            st_d.own_hi[win_idx]      = sp_hi;
            st_d.occ[trk_sel]         = st_d.occ[trk_sel] | sp_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    segbus_xp_map #(.N_PE(N_PE), .N_TRK(N_TRK), .IW(IW), .TW(TW)) u_xp (
        .own_vld  (st_q.own_vld),
        .own_trk  (st_q.own_trk),
        .own_lo   (st_q.own_lo),
        .own_hi   (st_q.own_hi),
        .xp_close (xp_close)
    );

    assign resp_vld = st_q.resp_vld;
    assign resp_ok  = st_q.resp_ok;
    assign resp_src = st_q.resp_src;
    assign resp_trk = st_q.resp_trk;
    assign seg_busy = st_q.occ;
endmodule

// File: rtl/segbus_xbar_chk.sv
module segbus_xbar_chk #(
    parameter int N_PE  = 6,
    parameter int N_TRK = 4,
    parameter int IW    = 3,
    parameter int TW    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_PE-1:0]           req_vld,
    input logic [N_PE-1:0]           rel,
    input logic                      resp_vld,
    input logic                      resp_ok,
    input logic [IW-1:0]             resp_src,
    input logic [TW-1:0]             resp_trk,
    input logic [N_TRK*N_PE-1:0]     seg_busy,
    input logic [(N_PE-1)*N_TRK-1:0] xp_close
);
    logic [N_PE-1:0]       prev_req;
    logic [N_PE-1:0]       prev_rel;
    logic [N_TRK*N_PE-1:0] prev_seg;
    logic [N_PE-1:0]       below_src;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_req <= '0;
            prev_rel <= '0;
            prev_seg <= '0;
        end else begin
            prev_req <= req_vld;
            prev_rel <= rel;
            prev_seg <= seg_busy;
        end
    end

    always_comb begin
        below_src = '0;
        for (int i = 0; i < N_PE; i++) begin
            if (IW'(i) < resp_src) below_src[i] = 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!resp_vld && (seg_busy == '0) && (xp_close == '0)));

    // R6
    resp_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> (prev_req[resp_src] && ((prev_req & below_src) == '0)));

    // R6
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_req == '0) |-> !resp_vld);

    // R3
    grant_src_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_ok) |-> seg_busy[resp_trk*N_PE + resp_src]);

    // R4
    busy_trk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && !resp_ok) |-> (resp_trk == '0));

    // R2
    seg_set_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_vld && resp_ok) |-> ((seg_busy & ~prev_seg) == '0));

    // R8
    quiet_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(resp_vld && resp_ok) && (prev_rel == '0)) |-> (seg_busy == prev_seg));

    for (genvar j = 0; j < N_PE - 1; j++) begin : g_gap
        for (genvar t = 0; t < N_TRK; t++) begin : g_trk
            // R3
            xp_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                xp_close[j*N_TRK + t] |-> (seg_busy[t*N_PE + j] && seg_busy[t*N_PE + j + 1]));
        end
    end
endmodule

bind segbus_xbar_ctrl segbus_xbar_chk #(
    .N_PE(N_PE), .N_TRK(N_TRK), .IW(IW), .TW(TW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .rel      (rel),
    .resp_vld (resp_vld),
    .resp_ok  (resp_ok),
    .resp_src (resp_src),
    .resp_trk (resp_trk),
    .seg_busy (seg_busy),
    .xp_close (xp_close)
);

// File: tb/tb_segbus_xbar_ctrl.sv
`timescale 1ns/1ps
module tb_segbus_xbar_ctrl;
    localparam int NP = 6;
    localparam int NT = 4;
    localparam int IW = 3;
    localparam int TW = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        req_vld = '0;
    logic [NP*IW-1:0]     req_dst = '0;
    logic [NP-1:0]        rel = '0;
    logic                 resp_vld, resp_ok;
    logic [IW-1:0]        resp_src;
    logic [TW-1:0]        resp_trk;
    logic [NT*NP-1:0]     seg_busy;
    logic [(NP-1)*NT-1:0] xp_close;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit m_vld [NP];
    int m_trk [NP];
    int m_lo  [NP];
    int m_hi  [NP];
    bit m_occ [NT][NP];

    always #2.5 clk = ~clk;

    segbus_xbar_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dst(req_dst), .rel(rel),
        .resp_vld(resp_vld), .resp_ok(resp_ok), .resp_src(resp_src), .resp_trk(resp_trk),
        .seg_busy(seg_busy), .xp_close(xp_close)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_seg();
        logic [31:0] v = '0;
        for (int t = 0; t < NT; t++)
            for (int c = 0; c < NP; c++)
                if (m_occ[t][c]) v[t*NP + c] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] exp_xp();
        logic [31:0] v = '0;
        for (int i = 0; i < NP; i++)
            if (m_vld[i])
                for (int j = m_lo[i]; j < m_hi[i]; j++) v[j*NT + m_trk[i]] = 1'b1;
        return v;
    endfunction

    function automatic logic [NP*IW-1:0] dv(input int i, input int d);
        logic [NP*IW-1:0] v = '0;
        v[i*IW +: IW] = IW'(d);
        return v;
    endfunction

    // one stimulus cycle: drive at a falling edge, check at the next falling edge
    task automatic step(input logic [NP-1:0] rq, input logic [NP*IW-1:0] ds, input logic [NP-1:0] rl);
        int w, d, lo, hi, trk, nreq;
        bit ok_req, found, grant, freed;
        string rtag, stag;
        logic [31:0] e_resp;
        req_vld = rq; req_dst = ds; rel = rl;
        w = -1; nreq = 0;
        for (int i = NP - 1; i >= 0; i--) if (rq[i]) begin w = i; nreq++; end
        grant = 0; found = 0; trk = 0; ok_req = 0; d = 0; lo = 0; hi = 0;
        if (w >= 0) begin
            d = int'(ds[w*IW +: IW]);
            lo = (w < d) ? w : d;
            hi = (w < d) ? d : w;
            ok_req = (d < NP) && (d != w) && !m_vld[w];
            for (int t = NT - 1; t >= 0; t--) begin
                bit fr = 1;
                for (int c = lo; c <= hi; c++) if (c < NP && m_occ[t][c]) fr = 0;
                if (fr) begin found = 1; trk = t; end
            end
            grant = ok_req && found;
        end
        if (w < 0)            rtag = "R6";
        else if (nreq > 1)    rtag = "R6";
        else if (!ok_req)     rtag = "R5";
        else if (!found)      rtag = "R4";
        else if (rl != 0)     rtag = "R10";
        else if (d < w)       rtag = "R9";
        else                  rtag = "R2";
        e_resp = '0;
        if (w >= 0) e_resp = {26'd0, 1'b1, grant, IW'(w), grant ? TW'(trk) : TW'(0)};
        freed = 0;
        for (int i = 0; i < NP; i++)
            if (rl[i] && m_vld[i]) begin
                freed = 1;
                m_vld[i] = 0;
                for (int c = m_lo[i]; c <= m_hi[i]; c++) m_occ[m_trk[i]][c] = 0;
            end
        if (grant) begin
            m_vld[w] = 1; m_trk[w] = trk; m_lo[w] = lo; m_hi[w] = hi;
            for (int c = lo; c <= hi; c++) m_occ[trk][c] = 1;
        end
        if (grant)          stag = "R3";
        else if (freed)     stag = "R7";
        else if (rl != 0)   stag = "R8";
        else                stag = rtag;
        @(posedge clk);
        @(negedge clk);
        if (w >= 0)
            chk(rtag, "response", {26'd0, resp_vld, resp_ok, resp_src, resp_trk}, e_resp);
        else
            chk(rtag, "response", {31'd0, resp_vld}, 32'd0);
        chk(stag, "seg_busy", 32'(seg_busy), exp_seg());
        chk(stag, "xp_close", 32'(xp_close), exp_xp());
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        if (!done) $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            m_vld[i] = 0; m_trk[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
            for (int t = 0; t < NT; t++) m_occ[t][i] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs idle during reset
        chk("R1", "resp in reset", {31'd0, resp_vld}, 32'd0);
        chk("R1", "seg in reset", 32'(seg_busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "resp after reset", {31'd0, resp_vld}, 32'd0);
        chk("R1", "xp after reset", 32'(xp_close), 32'd0);

        step(6'b000001, dv(0, 3), '0);                    // R2 track 0
        step(6'b010010, dv(1, 2) | dv(4, 0), '0);         // R6 sender 1 wins, track 1
        step(6'b010000, dv(4, 0), '0);                    // R9 reverse span, track 2
        step(6'b100000, dv(5, 2), '0);                    // track 3
        step(6'b000100, dv(2, 3), '0);                    // R4 all tracks taken
        step(6'b000100, dv(2, 2), '0);                    // R5 target equals sender
        step(6'b000100, dv(2, 7), '0);                    // R5 target out of range
        step(6'b000001, dv(0, 1), '0);                    // R5 sender owns a circuit
        step('0, '0, 6'b001000);                          // R8 release without circuit
        step(6'b000100, dv(2, 3), 6'b000001);             // R10 pre-release view: busy
        step(6'b000100, dv(2, 3), '0);                    // now granted on track 0
        step('0, '0, 6'b111111);                          // R7 release all

        void'($urandom(32'd20240611));
        for (int n = 0; n < 4000; n++) begin
            logic [NP-1:0]    rq = '0;
            logic [NP-1:0]    rl = '0;
            logic [NP*IW-1:0] ds = '0;
            for (int i = 0; i < NP; i++) begin
                rq[i] = ($urandom % 4) == 0;
                rl[i] = ($urandom % 8) == 0;
                ds[i*IW +: IW] = IW'($urandom % 8);
            end
            step(rq, ds, rl);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule